// File: doc/BRIEF.md
# Asynchronous Static-Memory Bus Controller

This block turns single-beat requests from an internal port into cycles on an external asynchronous bus with a 16-bit data path. It drives an active-low chip enable, output enable and write enable, a read/not-write line, a halfword address and write data. It also samples a WAIT input from the external device. Every bus cycle runs through three timed phases: setup, strobe and hold. Each phase length comes from its own field of a packed configuration word, with separate values for reads and writes. A turnaround gap is inserted when the access direction changes.

A request marked wide carries 32 bits. It is performed as two 16-bit bus cycles: the lower halfword first at the given address, then the upper halfword at the next halfword address. Output enable goes high between the two halves, and a wide read returns both halves as one response word. When the requester already has a request of the same direction waiting as an access finishes, chip enable stays low and the next setup phase follows at once. When WAIT is enabled it stretches the strobe phase, up to a programmable cycle limit. Running out that limit ends the strobe and sets a sticky timeout flag.

Top module: `aemc_top`

## Requirements
- R1: The configuration word is decoded with these bit positions: bit 31 strobe-only chip enable, bit 30 WAIT enable, [29:26] write setup, [25:20] write strobe, [19:17] write hold, [16:13] read setup, [12:7] read strobe, [6:4] read hold, [3:2] turnaround. Bits [1:0] hold the bus width code, where 1 means a 16-bit bus, and the block always works at 16 bits.
- R2: A timing field of value n makes its phase last n+1 clock cycles. This holds for every phase of reads and writes.
- R3: After a request is accepted in the idle state, the setup phase starts in the next cycle. During a read, bus_rnw is high throughout and bus_oe_n is low only during the strobe phase. Data is taken from bus_din on the last strobe cycle. rsp_valid is high for exactly one cycle, the cycle after the hold phase ends. req_ready is high while idle.
- R4: A wide access runs two complete setup/strobe/hold sequences. The first is at req_addr and moves bits [15:0]. The second is at req_addr+1 and moves bits [31:16]. bus_oe_n is high and bus_ce_n stays low between them. A wide read returns {upper, lower}. A narrow read returns zero in bits [31:16].
- R5: During a write, bus_rnw is low, bus_dout_en is high and bus_we_n is low only in the strobe phase, with the current halfword on bus_dout. Writes produce no rsp_valid pulse.
- R6: When a same-direction request is valid on the last hold cycle of an access, it is accepted there. Chip enable stays low and its setup begins in the next cycle. With no request pending, chip enable goes high and the block idles.
- R7: When the new access direction differs from the previous access, turnaround-field+1 cycles with all strobes and chip enable high come before setup. No gap is added when the direction stays the same.
- R8: With WAIT enabled, an active WAIT on the last strobe cycle extends the strobe by one cycle, and this repeats. wait_pol=1 makes WAIT active high and wait_pol=0 makes it active low. With WAIT disabled, the input has no effect on timing.
- R9: When WAIT is still active after wait_max extension cycles, the strobe ends anyway and timeout_flag is set. The flag stays set until reset.
- R10: With the strobe-only chip enable bit set, bus_ce_n is low only during strobe phases.
- R11: Out of reset, bus_ce_n, bus_oe_n, bus_we_n and bus_rnw are high, and rsp_valid, timeout_flag and bus_dout_en are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 32 | Packed timing and mode configuration |
| wait_max | input | WCW | Maximum number of WAIT extension cycles |
| wait_pol | input | 1 | 1: WAIT active high, 0: WAIT active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_write | input | 1 | 1 write, 0 read |
| req_wide | input | 1 | 1: 32-bit request split into two halves |
| req_addr | input | AW | Halfword address |
| req_wdata | input | 32 | Write data, lower half sent first |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | 32 | Read response data |
| timeout_flag | output | 1 | Sticky WAIT timeout indication |
| bus_ce_n | output | 1 | Chip enable, active low |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_we_n | output | 1 | Write enable, active low |
| bus_rnw | output | 1 | High for reads and idle, low for writes |
| bus_addr | output | AW | External halfword address |
| bus_dout | output | 16 | External write data |
| bus_dout_en | output | 1 | Drive enable for bus_dout |
| bus_din | input | 16 | External read data |
| bus_wait | input | 1 | External WAIT |

## Verification
The hardest situation to reach from the ports is the back-to-back chain. There a second request must be seen on the single hold cycle where req_ready rises in the middle of an access. The bench presents the second request right after the first is accepted and holds it valid until it is taken. It then measures one unbroken chip-enable-low run covering both accesses, along with two responses. WAIT stretching and timeout need WAIT to be active exactly at the end of the programmed strobe. The bench device model therefore keeps WAIT active for a chosen number of strobe cycles, so the stretch length and the timeout point both follow arithmetically from the strobe field and wait_max.

// File: rtl/aemc_pkg.sv
`timescale 1ns/1ps
package aemc_pkg;
  localparam int TW = 6;

  typedef enum logic [2:0] {PH_IDLE, PH_TURN, PH_SETUP, PH_STROBE, PH_HOLD} phase_t;

  // Field value (phase lasts value+1 cycles) for the phase about to start.
  function automatic logic [TW-1:0] phase_len(input logic [31:0] cfg, input phase_t ph,
                                              input logic wr);
    case (ph)
      PH_TURN:   return {4'd0, cfg[3:2]};
      PH_SETUP:  return wr ? {2'd0, cfg[29:26]} : {2'd0, cfg[16:13]};
      PH_STROBE: return wr ? cfg[25:20] : cfg[12:7];
      PH_HOLD:   return wr ? {3'd0, cfg[19:17]} : {3'd0, cfg[6:4]};
      default:   return '0;
    endcase
  endfunction
endpackage

// File: rtl/aemc_phase_timer.sv
`timescale 1ns/1ps
module aemc_phase_timer #(
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          last
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign last = (cnt == '0);
endmodule

// File: rtl/aemc_wait_ext.sv
`timescale 1ns/1ps
module aemc_wait_ext #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          pol,
  input  logic          wait_in,
  input  logic [CW-1:0] max_cnt,
  input  logic          at_end,
  output logic          stretch,
  output logic          timeout
);
  logic [CW-1:0] cnt;
  logic          act;
  logic          want;

  assign act     = pol ? wait_in : ~wait_in;
  assign want    = at_end && en && act;
  assign stretch = want && (cnt != max_cnt);
  assign timeout = want && (cnt == max_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (stretch) cnt <= cnt + 1'b1;
    else              cnt <= '0;
  end

  // R9: extension count never passes the programmed limit
  a_r9_wait_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= max_cnt);
endmodule

// File: rtl/aemc_top.sv
`timescale 1ns/1ps
module aemc_top #(
  parameter int AW  = 16,
  parameter int WCW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [31:0]    cfg_word,
  input  logic [WCW-1:0] wait_max,
  input  logic           wait_pol,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_write,
  input  logic           req_wide,
  input  logic [AW-1:0]  req_addr,
  input  logic [31:0]    req_wdata,
  output logic           rsp_valid,
  output logic [31:0]    rsp_rdata,
  output logic           timeout_flag,
  output logic           bus_ce_n,
  output logic           bus_oe_n,
  output logic           bus_we_n,
  output logic           bus_rnw,
  output logic [AW-1:0]  bus_addr,
  output logic [15:0]    bus_dout,
  output logic           bus_dout_en,
  input  logic [15:0]    bus_din,
  input  logic           bus_wait
);
  import aemc_pkg::*;
  localparam int HW = 16;

  phase_t          ph, ph_nx;
  logic            cur_wr, cur_wide, half, have_last;
  logic [AW-1:0]   cur_addr;
  logic [31:0]     cur_wdata;
  logic [HW-1:0]   rd_lo, rd_hi;
  logic            t_last, stretch, tmo;
  logic            cfg_ss, cfg_ext, unused_size;

  assign cfg_ss      = cfg_word[31];
  assign cfg_ext     = cfg_word[30];
  assign unused_size = ^cfg_word[1:0];

  // Named internal events
  logic active, strobe_last, phase_done, final_half, access_done;
  logic accept, dir_change, nx_wr, t_load;
  logic [TW-1:0] t_val;

  assign active      = ph inside {PH_SETUP, PH_STROBE, PH_HOLD};
  assign strobe_last = (ph == PH_STROBE) && t_last;
  assign phase_done  = t_last && !stretch;
  assign final_half  = !cur_wide || half;
  assign access_done = (ph == PH_HOLD) && phase_done && final_half;
  assign req_ready   = (ph == PH_IDLE) || access_done;
  assign accept      = req_valid && req_ready;
  assign dir_change  = have_last && (req_write != cur_wr);
  assign nx_wr       = accept ? req_write : cur_wr;

  always_comb begin
    ph_nx = ph;
    case (ph)
      PH_IDLE:   if (accept) ph_nx = dir_change ? PH_TURN : PH_SETUP;
      PH_TURN:   if (t_last) ph_nx = PH_SETUP;
      PH_SETUP:  if (t_last) ph_nx = PH_STROBE;
      PH_STROBE: if (phase_done) ph_nx = PH_HOLD;
      PH_HOLD: begin
        if (phase_done) begin
          if (!final_half)  ph_nx = PH_SETUP;
          else if (accept)  ph_nx = dir_change ? PH_TURN : PH_SETUP;
          else              ph_nx = PH_IDLE;
        end
      end
      default: ph_nx = PH_IDLE;
    endcase
  end

  assign t_load = (ph_nx != ph);
  assign t_val  = phase_len(cfg_word, ph_nx, nx_wr);

  aemc_phase_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .last(t_last)
  );

  aemc_wait_ext #(.CW(WCW)) u_wait (
    .clk(clk), .rst_n(rst_n), .en(cfg_ext), .pol(wait_pol), .wait_in(bus_wait),
    .max_cnt(wait_max), .at_end(strobe_last), .stretch(stretch), .timeout(tmo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph           <= PH_IDLE;
      cur_wr       <= 1'b0;
      cur_wide     <= 1'b0;
      half         <= 1'b0;
      have_last    <= 1'b0;
      cur_addr     <= '0;
      cur_wdata    <= '0;
      rd_lo        <= '0;
      rd_hi        <= '0;
      rsp_valid    <= 1'b0;
      rsp_rdata    <= '0;
      timeout_flag <= 1'b0;
    end else begin
      ph        <= ph_nx;
      rsp_valid <= access_done && !cur_wr;
      if (access_done)
        rsp_rdata <= cur_wide ? {rd_hi, rd_lo} : {{HW{1'b0}}, rd_lo};
      if (tmo) timeout_flag <= 1'b1;
      if (strobe_last && phase_done && !cur_wr) begin
        if (half) rd_hi <= bus_din;
        else      rd_lo <= bus_din;
      end
      if (accept) begin
        cur_wr    <= req_write;
        cur_wide  <= req_wide;
        cur_addr  <= req_addr;
        cur_wdata <= req_wdata;
        half      <= 1'b0;
        have_last <= 1'b1;
      end else if ((ph == PH_HOLD) && phase_done && !final_half) begin
        half <= 1'b1;
      end
    end
  end

  assign bus_ce_n    = cfg_ss ? (ph != PH_STROBE) : !active;
  assign bus_oe_n    = !((ph == PH_STROBE) && !cur_wr);
  assign bus_we_n    = !((ph == PH_STROBE) && cur_wr);
  assign bus_rnw     = !(active && cur_wr);
  assign bus_addr    = cur_addr + AW'(half);
  assign bus_dout    = half ? cur_wdata[31:16] : cur_wdata[15:0];
  assign bus_dout_en = active && cur_wr;

  // R3: output enable only while reading with the chip selected
  a_r3_oe_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe_n |-> (bus_rnw && bus_we_n && !bus_ce_n));
  // R5: write enable only while driving write data
  a_r5_we_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we_n |-> (!bus_rnw && bus_dout_en && bus_oe_n));
  // R3: response is a single-cycle pulse
  a_r3_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R9: timeout indication is sticky
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_flag |=> timeout_flag);
  // R6: a pending same-direction request keeps the chip selected
  a_r6_ce_held: assert property (@(posedge clk) disable iff (!rst_n)
    (access_done && req_valid && (req_write == cur_wr) && !cfg_ss) |=> !bus_ce_n);
  // R4: second half only exists for wide accesses
  a_r4_half_wide: assert property (@(posedge clk) disable iff (!rst_n)
    (half && active) |-> cur_wide);
endmodule

// File: tb/aemc_top_test.sv
`timescale 1ns/1ps
module aemc_top_test;
  localparam int AW  = 16;
  localparam int WCW = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [31:0]    cfg_word = 32'h1;
  logic [WCW-1:0] wait_max = 8'h80;
  logic           wait_pol = 1'b0;
  logic           req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
  logic [AW-1:0]  req_addr = '0;
  logic [31:0]    req_wdata = '0;
  logic           req_ready, rsp_valid, timeout_flag;
  logic [31:0]    rsp_rdata;
  logic           bus_ce_n, bus_oe_n, bus_we_n, bus_rnw, bus_dout_en, bus_wait;
  logic [AW-1:0]  bus_addr;
  logic [15:0]    bus_dout, bus_din;
  logic           w_act = 1'b0;

  always #10 clk = ~clk;

  assign bus_wait = wait_pol ? w_act : ~w_act;
  assign bus_din  = bus_oe_n ? 16'hDEAD : (bus_addr ^ 16'h5A3C);

  aemc_top #(.AW(AW), .WCW(WCW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .wait_max(wait_max),
    .wait_pol(wait_pol), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_wide(req_wide), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .timeout_flag(timeout_flag), .bus_ce_n(bus_ce_n), .bus_oe_n(bus_oe_n),
    .bus_we_n(bus_we_n), .bus_rnw(bus_rnw), .bus_addr(bus_addr),
    .bus_dout(bus_dout), .bus_dout_en(bus_dout_en), .bus_din(bus_din),
    .bus_wait(bus_wait)
  );

  int n_chk = 0, n_err = 0;
  int c_rs, c_rt, c_rh, c_ws, c_wt, c_wh, c_ta;
  logic c_ext = 1'b0, c_ss = 1'b0;
  logic have_last = 1'b0, last_w = 1'b0, tmo_seen = 1'b0;
  int tl_bad;
  logic [31:0] tl_act, tl_exp;

  function automatic logic [15:0] dev(input logic [15:0] a);
    return a ^ 16'h5A3C;
  endfunction

  // R1 field positions
  function automatic logic [31:0] mk_cfg();
    return {c_ss, c_ext, 4'(c_ws), 6'(c_wt), 3'(c_wh), 4'(c_rs), 6'(c_rt), 3'(c_rh),
            2'(c_ta), 2'b01};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input logic [3:0] ec, input logic ua, input logic [15:0] ea,
                     input logic ud, input logic [15:0] ed);
    logic [3:0] oc;
    oc = {bus_ce_n, bus_oe_n, bus_we_n, bus_rnw};
    if (tl_bad == 0) begin
      if (oc != ec) begin
        tl_bad = 1; tl_act = {28'h0, oc}; tl_exp = {28'h0, ec};
      end else if (ua && bus_addr != ea) begin
        tl_bad = 2; tl_act = {16'h0, bus_addr}; tl_exp = {16'h0, ea};
      end else if (ud && (bus_dout != ed || !bus_dout_en)) begin
        tl_bad = 3; tl_act = {15'h0, bus_dout_en, bus_dout}; tl_exp = {15'h0, 1'b1, ed};
      end
    end
    @(negedge clk);
  endtask

  task automatic access(input logic w, input logic wide, input logic [15:0] a,
                        input logic [31:0] wd, input int dly, input string tag);
    int pre, s, t, hd, m, nh;
    logic tmo_exp;
    logic [31:0] rexp;
    pre = (have_last && (w != last_w)) ? c_ta + 1 : 0;
    s  = w ? c_ws : c_rs;
    t  = w ? c_wt : c_rt;
    hd = w ? c_wh : c_rh;
    m  = c_ext ? ((dly > int'(wait_max)) ? int'(wait_max) : dly) : 0;
    tmo_exp = c_ext && (dly > int'(wait_max));
    nh = wide ? 2 : 1;
    rexp = wide ? {dev(a + 16'd1), dev(a)} : {16'h0, dev(a)};
    cfg_word = mk_cfg();
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_wide = wide; req_addr = a; req_wdata = wd;
    #1;
    check(req_ready == 1'b1, tag, "ready while idle", {31'h0, req_ready}, 32'h1);
    @(negedge clk);
    req_valid = 1'b0;
    tl_bad = 0; tl_act = 0; tl_exp = 0;
    for (int k = 0; k < pre; k++) cyc(4'b1111, 1'b0, 16'h0, 1'b0, 16'h0);
    for (int hh = 0; hh < nh; hh++) begin
      logic [15:0] ha, hwd;
      ha  = a + 16'(hh);
      hwd = (hh != 0) ? wd[31:16] : wd[15:0];
      for (int k = 0; k < s + 1; k++) cyc({c_ss, 1'b1, 1'b1, ~w}, 1'b1, ha, 1'b0, 16'h0);
      for (int j = 0; j < t + 1 + m; j++) begin
        w_act = (j < t + dly);
        cyc({1'b0, w, ~w, ~w}, 1'b1, ha, w, hwd);
      end
      w_act = 1'b0;
      for (int k = 0; k < hd + 1; k++) cyc({c_ss, 1'b1, 1'b1, ~w}, 1'b1, ha, 1'b0, 16'h0);
    end
    check(tl_bad == 0, tag, $sformatf("bus timeline kind %0d", tl_bad), tl_act, tl_exp);
    if (!w)
      check(rsp_valid && rsp_rdata == rexp, tag, "read response", rsp_rdata, rexp);
    else
      check(!rsp_valid, tag, "no response on write", {31'h0, rsp_valid}, 32'h0);
    check(bus_ce_n == 1'b1, "R6", "ce released when nothing pending", {31'h0, bus_ce_n}, 32'h1);
    tmo_seen = tmo_seen | tmo_exp;
    check(timeout_flag == tmo_seen, tag, "timeout flag", {31'h0, timeout_flag},
          {31'h0, tmo_seen});
    have_last = 1'b1; last_w = w;
  endtask

  task automatic chain_reads(input logic [15:0] a1, input logic [15:0] a2);
    int low, nr, guard, exp_low;
    logic [31:0] d1, d2;
    logic pend_clear;
    cfg_word = mk_cfg();
    exp_low = 2 * (c_rs + c_rt + c_rh + 3);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_wide = 1'b0; req_addr = a1;
    @(negedge clk);
    req_addr = a2;
    low = 0; nr = 0; guard = 0; d1 = 0; d2 = 0; pend_clear = 1'b0;
    while (guard < 200) begin
      guard++;
      if (pend_clear) begin req_valid = 1'b0; pend_clear = 1'b0; end
      if (rsp_valid) begin
        if (nr == 0) d1 = rsp_rdata; else d2 = rsp_rdata;
        nr++;
      end
      if (!bus_ce_n) low++;
      else if (low > 0) break;
      if (req_valid && req_ready) pend_clear = 1'b1;
      @(negedge clk);
    end
    req_valid = 1'b0;
    check(low == exp_low, "R6", "unbroken ce low run", 32'(low), 32'(exp_low));
    check(nr == 2, "R6", "two responses", 32'(nr), 32'd2);
    check(d1 == {16'h0, dev(a1)}, "R6", "first chained data", d1, {16'h0, dev(a1)});
    check(d2 == {16'h0, dev(a2)}, "R6", "second chained data", d2, {16'h0, dev(a2)});
    have_last = 1'b1; last_w = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    c_rs = 1; c_rt = 1; c_rh = 0; c_ws = 1; c_wt = 1; c_wh = 0; c_ta = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check({bus_ce_n, bus_oe_n, bus_we_n, bus_rnw} == 4'b1111, "R11", "strobes in reset",
          {28'h0, bus_ce_n, bus_oe_n, bus_we_n, bus_rnw}, 32'hF);
    check(!rsp_valid && !timeout_flag && !bus_dout_en, "R11", "flags in reset",
          {29'h0, rsp_valid, timeout_flag, bus_dout_en}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R11", "ready after reset", {31'h0, req_ready}, 32'h1);

    // Timing sweep with direction changes (R1 R2 R3 R4 R5 R7)
    for (int rs = 0; rs < 3; rs++)
      for (int rt = 0; rt < 3; rt++)
        for (int rh = 0; rh < 2; rh++) begin
          logic [15:0] ba;
          c_rs = rs; c_rt = rt; c_rh = rh;
          c_ws = rt; c_wt = rs + 1; c_wh = 1 - rh; c_ta = (rs + rt) % 4;
          ba = 16'h0100 + 16'(rs * 48 + rt * 16 + rh * 4);
          access(1'b0, 1'b0, ba, 32'h0, 0, "R1 R2 R3");
          access(1'b1, 1'b1, ba + 16'd2, {ba, ~ba}, 0, "R2 R5 R4 R7");
          access(1'b0, 1'b1, ba + 16'd2, 32'h0, 0, "R2 R4 R7");
          access(1'b1, 1'b0, ba, {16'h0, ba ^ 16'h0F0F}, 0, "R1 R5 R7");
        end

    // Same direction, no turnaround (R7)
    c_rs = 1; c_rt = 2; c_rh = 0; c_ws = 0; c_wt = 1; c_wh = 0; c_ta = 3;
    access(1'b0, 1'b0, 16'h0400, 32'h0, 0, "R7 after write");
    access(1'b0, 1'b0, 16'h0402, 32'h0, 0, "R7 same direction");

    // WAIT stretching, both polarities, and disabled (R8)
    c_ext = 1'b1; wait_max = 8'd5;
    wait_pol = 1'b0; access(1'b0, 1'b0, 16'h0500, 32'h0, 2, "R8 active low");
    wait_pol = 1'b1; access(1'b1, 1'b1, 16'h0502, 32'hCAFE1234, 3, "R8 active high");
    wait_pol = 1'b1; access(1'b0, 1'b1, 16'h0504, 32'h0, 5, "R8 at limit");
    c_ext = 1'b0;
    access(1'b0, 1'b0, 16'h0506, 32'h0, 4, "R8 wait ignored when disabled");
    wait_pol = 1'b0; wait_max = 8'h80;

    // Strobe-only chip enable (R10)
    c_ss = 1'b1;
    access(1'b0, 1'b1, 16'h0600, 32'h0, 0, "R10 read");
    access(1'b1, 1'b0, 16'h0602, 32'h00005555, 0, "R10 write");
    c_ss = 1'b0;

    // Back-to-back chaining (R6)
    access(1'b0, 1'b0, 16'h0700, 32'h0, 0, "R3 before chain");
    chain_reads(16'h0710, 16'h0722);

    // Timeout and stickiness (R9)
    c_ext = 1'b1; wait_max = 8'd3; wait_pol = 1'b1;
    access(1'b0, 1'b0, 16'h0800, 32'h0, 50, "R9 timeout");
    c_ext = 1'b0;
    access(1'b0, 1'b0, 16'h0802, 32'h0, 0, "R9 flag stays set");

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule